// File: doc/BRIEF.md
# Snapshot Counter Timer with Compare Channels

This peripheral keeps a free-running 64-bit tick count, advanced by a programmable prescaler, and offers six 32-bit compare channels against the low word of that count. Each channel has a sticky event flag and an interrupt enable. The highest channel can also fire a one-cycle watchdog reset pulse. Software sits on a plain 32-bit register bus. Writes take one cycle, and read data is combinational from the word address.

The full count cannot be read as a single word on this bus. Software therefore issues a snapshot command first, and then reads two held halves. Both halves always come from the same count value. The count can be loaded one half at a time, for example to zero it at start-up. A match never stops or reloads the counter.

Top module: `match_timer`

## Requirements
- R1: After the active-low asynchronous reset, every register reads 0, every irq_o bit is 0 and wdog_rst_o is 0.
- R2: With divider value D (register at byte 0x2C, low 16 bits), the count advances once every 2*(D+1) clocks. Any write to the divider restarts the prescaler phase from zero, and no advance happens in the cycle of that write.
- R3: The count is 64 bits and carries from the low word (0x00) into the high word (0x04). It wraps from all-ones to zero. A write to either half replaces that half, and it suppresses the advance in that cycle.
- R4: A write to 0x30 with bit 0 = 1 copies the whole count, as it was before that clock edge, into the snapshot registers. These read at 0x34 (low) and 0x38 (high). They hold until the next such write. A write to 0x30 with bit 0 = 0 leaves them unchanged.
- R5: Flag n (bit n of 0x20) is set in the cycle after the low count word becomes equal to compare register n (0x08 + 4*n). The low word may become equal either by counting or by a write to the compare register. The flag is not set again while the two stay equal.
- R6: Writing 1 to bit n of 0x20 clears flag n, and writing 0 leaves it unchanged. Flags are otherwise sticky. If a set and a clear of the same flag fall in the same cycle, the flag ends set.
- R7: irq_o[n] is 1 exactly when flag n is set and bit n of the enable register at 0x24 is 1.
- R8: When bit 0 of 0x28 is 1, a set event of flag 5 also drives wdog_rst_o high for exactly one cycle, in the same cycle that the flag first reads 1. When bit 0 of 0x28 is 0, no pulse occurs.
- R9: Registers read back at their offsets. The command register 0x30 and all offsets from 0x3C upward read 0.
- R10: A compare event does not alter the count. The count keeps advancing at the prescaled rate through any match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 8 | Byte address; bits 7:2 select the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word |
| irq_o | output | 6 | Per-channel interrupt, flag AND enable |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Compare targets are placed a few ticks ahead of the running count under prescaler settings 0 to 3. This separates correct edge detection from level detection and from off-by-one prescaler periods. Back-to-back clear writes issued while a match lands show whether set beats clear. Loading the low word with all-ones before a snapshot tells a true 64-bit carry and a coherent two-half copy apart from independent halves. Watchdog runs with the enable on and off separate the pulse from the plain flag. Random bursts of writes, snapshots and reads to every offset are compared cycle by cycle against a bench model of the register map.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int WIDX_W = AW - 2;
  // word indices (byte offset / 4)
  localparam logic [WIDX_W-1:0] W_CNT_LO = 6'd0;
  localparam logic [WIDX_W-1:0] W_CNT_HI = 6'd1;
  localparam logic [WIDX_W-1:0] W_MATCH0 = 6'd2;
  localparam logic [WIDX_W-1:0] W_STAT   = 6'd8;
  localparam logic [WIDX_W-1:0] W_IEN    = 6'd9;
  localparam logic [WIDX_W-1:0] W_WDEN   = 6'd10;
  localparam logic [WIDX_W-1:0] W_DIV    = 6'd11;
  localparam logic [WIDX_W-1:0] W_LATCH  = 6'd12;
  localparam logic [WIDX_W-1:0] W_LAT_LO = 6'd13;
  localparam logic [WIDX_W-1:0] W_LAT_HI = 6'd14;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  // period is 2*(div+1): last phase index is 2*div+1
  assign lim    = {div_i, 1'b1};
  assign tick_o = (pre_q == lim) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (restart_i)       pre_q <= '0;
    else if (pre_q == lim)    pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int HW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [HW-1:0]   wdata_i,
  input  logic            latch_i,
  output logic [2*HW-1:0] cnt_o,
  output logic [2*HW-1:0] lat_o
);
  localparam int CW = 2 * HW;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_q[HW-1:0]  <= wdata_i;
      if (wr_hi_i) cnt_q[CW-1:HW] <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= '0;
    else if (latch_i) lat_q <= cnt_q;
  end

  assign cnt_o = cnt_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan #(
  parameter int HW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] cmp_i,
  input  logic [HW-1:0] cnt_lo_i,
  input  logic          clr_i,
  output logic          hit_o,
  output logic          flag_o
);
  logic eq;
  logic eq_q;
  logic flag_q;

  assign eq    = (cnt_lo_i == cmp_i);
  // entry into equality only; eq_q resets high so reset state 0==0 is not an event
  assign hit_o = eq && !eq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_q   <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      eq_q   <= eq;
      flag_q <= (flag_q && !clr_i) || hit_o;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import tmr_pkg::*;
#(
  parameter int N_CH  = 6,   // at most 6 with this address map
  parameter int DIV_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N_CH-1:0] irq_o,
  output logic            wdog_rst_o
);
  localparam int WD_CH = N_CH - 1;
  localparam int CW    = 2 * DW;

  logic [WIDX_W-1:0] widx;
  logic              wr_lo, wr_hi, wr_stat, wr_ien, wr_wden, wr_div;
  logic              latch_cmd;
  logic [N_CH-1:0]   wr_match;

  logic [DW-1:0]     match_q [N_CH];
  logic [N_CH-1:0]   ien_q;
  logic              wden_q;
  logic [DIV_W-1:0]  div_q;
  logic              wdog_q;

  logic              tick;
  logic              cnt_wr;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     lat;
  logic [N_CH-1:0]   hit;
  logic [N_CH-1:0]   status_q;

  assign widx      = addr_i[AW-1:2];
  assign wr_lo     = we_i && (widx == W_CNT_LO);
  assign wr_hi     = we_i && (widx == W_CNT_HI);
  assign wr_stat   = we_i && (widx == W_STAT);
  assign wr_ien    = we_i && (widx == W_IEN);
  assign wr_wden   = we_i && (widx == W_WDEN);
  assign wr_div    = we_i && (widx == W_DIV);
  assign latch_cmd = we_i && (widx == W_LATCH) && wdata_i[0];
  assign cnt_wr    = wr_lo || wr_hi;

  tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div_q),
    .restart_i (wr_div),
    .tick_o    (tick)
  );

  tmr_counter #(.HW(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (wdata_i),
    .latch_i (latch_cmd),
    .cnt_o   (cnt),
    .lat_o   (lat)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    assign wr_match[n] = we_i && (widx == WIDX_W'(W_MATCH0 + n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          match_q[n] <= '0;
      else if (wr_match[n]) match_q[n] <= wdata_i;
    end

    tmr_match_chan #(.HW(DW)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmp_i    (match_q[n]),
      .cnt_lo_i (cnt[DW-1:0]),
      .clr_i    (wr_stat && wdata_i[n]),
      .hit_o    (hit[n]),
      .flag_o   (status_q[n])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      wden_q <= 1'b0;
      div_q  <= '0;
      wdog_q <= 1'b0;
    end else begin
      if (wr_ien)  ien_q  <= wdata_i[N_CH-1:0];
      if (wr_wden) wden_q <= wdata_i[0];
      if (wr_div)  div_q  <= wdata_i[DIV_W-1:0];
      wdog_q <= hit[WD_CH] && wden_q;
    end
  end

  assign irq_o      = status_q & ien_q;
  assign wdog_rst_o = wdog_q;

  always_comb begin
    rdata_o = '0;
    unique case (widx)
      W_CNT_LO: rdata_o = cnt[DW-1:0];
      W_CNT_HI: rdata_o = cnt[CW-1:DW];
      W_STAT:   rdata_o = DW'(status_q);
      W_IEN:    rdata_o = DW'(ien_q);
      W_WDEN:   rdata_o = DW'(wden_q);
      W_DIV:    rdata_o = DW'(div_q);
      W_LAT_LO: rdata_o = lat[DW-1:0];
      W_LAT_HI: rdata_o = lat[CW-1:DW];
      default: begin
        for (int n = 0; n < N_CH; n++)
          if (widx == WIDX_W'(W_MATCH0 + n)) rdata_o = match_q[n];
      end
    endcase
  end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import tmr_pkg::*;
#(
  parameter int N_CH = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic            wdog_rst_o,
  input logic [N_CH-1:0] status,
  input logic            wden,
  input logic            tick,
  input logic            cnt_wr,
  input logic            latch_cmd,
  input logic [2*DW-1:0] cnt,
  input logic [2*DW-1:0] lat
);
  localparam int WD_CH = N_CH - 1;

  logic stat_wr;
  assign stat_wr = we_i && (addr_i[AW-1:2] == W_STAT);

  for (genvar n = 0; n < N_CH; n++) begin : g_a
    assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status[n] && !(stat_wr && wdata_i[n]) |=> status[n]);
  end

  assert_wd_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |=> !wdog_rst_o);

  assert_wd_with_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |-> status[WD_CH] && $past(wden));

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !cnt_wr |=> cnt == $past(cnt) + 64'd1);

  assert_cnt_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick && !cnt_wr |=> $stable(cnt));

  assert_snap_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_cmd |=> lat == $past(cnt));

  assert_snap_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_cmd |=> $stable(lat));
endmodule

bind match_timer match_timer_chk #(.N_CH(N_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .wdog_rst_o (wdog_rst_o),
  .status     (status_q),
  .wden       (wden_q),
  .tick       (tick),
  .cnt_wr     (cnt_wr),
  .latch_cmd  (latch_cmd),
  .cnt        (cnt),
  .lat        (lat)
);

// File: tb/match_timer_bench.sv
module match_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq;
  logic        wdog;

  always #2.5 clk = ~clk;

  match_timer u_match_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .wdog_rst_o(wdog)
  );

  int n_chk = 0, n_bad = 0, wd_seen = 0, hi_seen = 0;

  // ---- reference model of the register map, updated at each clock edge ----
  logic [16:0] m_pre;
  logic [63:0] m_cnt, m_lat;
  logic [31:0] m_match [6];
  logic [5:0]  m_stat, m_ien, m_eqq, m_ev;
  logic        m_wden, m_wd, m_tick;
  logic [15:0] m_div;
  logic [5:0]  wi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = '0; m_cnt = '0; m_lat = '0; m_stat = '0; m_ien = '0;
      m_eqq = '1; m_wden = 0; m_wd = 0; m_div = '0;
      for (int i = 0; i < 6; i++) m_match[i] = '0;
    end else begin
      wi = addr[7:2];
      m_tick = (m_pre == {m_div, 1'b1}) && !(we && wi == 6'd11);
      for (int i = 0; i < 6; i++) begin
        m_ev[i]  = (m_cnt[31:0] == m_match[i]) && !m_eqq[i];
        m_eqq[i] = (m_cnt[31:0] == m_match[i]);
      end
      m_wd = m_ev[5] && m_wden;
      if (we && wi == 6'd12 && wdata[0]) m_lat = m_cnt;
      if (we && wi == 6'd11 || m_pre == {m_div, 1'b1}) m_pre = '0;
      else m_pre = m_pre + 1;
      if (we && (wi == 6'd0 || wi == 6'd1)) begin
        if (wi == 6'd0) m_cnt[31:0] = wdata; else m_cnt[63:32] = wdata;
      end else if (m_tick) m_cnt = m_cnt + 1;
      m_stat = (m_stat & ~((we && wi == 6'd8) ? wdata[5:0] : 6'd0)) | m_ev;
      for (int i = 0; i < 6; i++) if (we && wi == 6'(2 + i)) m_match[i] = wdata;
      if (we && wi == 6'd9)  m_ien  = wdata[5:0];
      if (we && wi == 6'd10) m_wden = wdata[0];
      if (we && wi == 6'd11) m_div  = wdata[15:0];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [5:0] w = a[7:2];
    case (w)
      6'd0:  return m_cnt[31:0];
      6'd1:  return m_cnt[63:32];
      6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7: return m_match[w - 6'd2];
      6'd8:  return {26'd0, m_stat};
      6'd9:  return {26'd0, m_ien};
      6'd10: return {31'd0, m_wden};
      6'd11: return {16'd0, m_div};
      6'd13: return m_lat[31:0];
      6'd14: return m_lat[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // outputs checked every cycle, away from the edge
  always @(negedge clk) if (rst_n) begin
    check("R7", {26'd0, irq}, {26'd0, m_stat & m_ien});
    check("R8", {31'd0, wdog}, {31'd0, m_wd});
    if (wdog) wd_seen++;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    @(negedge clk); we = 0; addr = a; #0.5;
    check(req, rdata, exp_rd(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1 rst_n = 0; idle(3);
    // R1 reset state
    for (int a = 0; a < 64; a += 4) begin
      @(negedge clk); addr = 8'(a); #0.5; check("R1", rdata, 32'd0);
    end
    check("R1", {25'd0, irq, wdog}, 32'd0);
    @(negedge clk); rst_n = 1;

    // R2 prescaler period with D=2: 6 clocks per advance
    wr(8'h2C, 32'd2);
    idle(24);
    rd("R2", 8'h00);
    check("R2", exp_rd(8'h00), 32'd4);
    // R3 carry into high word and wrap of low word
    wr(8'h2C, 32'd0);
    wr(8'h00, 32'hFFFF_FFFF);
    idle(3);
    wr(8'h30, 32'd1);
    rd("R4", 8'h34); rd("R4", 8'h38);
    rd("R3", 8'h04);
    check("R3", exp_rd(8'h04), 32'd1);
    // R4 bit0 = 0 leaves snapshot
    wr(8'h30, 32'd2); idle(5);
    rd("R4", 8'h34); rd("R4", 8'h38);
    // R9 command and unmapped offsets
    rd("R9", 8'h30); rd("R9", 8'h3C); rd("R9", 8'hFC);

    // R8 watchdog enabled: exactly one pulse
    wr(8'h28, 32'd1);
    wr(8'h00, 32'd100);
    wr(8'h1C, 32'd110);
    wd_seen = 0; idle(60);
    check("R8", wd_seen, 32'd1);
    rd("R5", 8'h20);
    rd("R10", 8'h00);
    wr(8'h20, 32'h3F); rd("R6", 8'h20);
    // watchdog disabled: flag only
    wr(8'h28, 32'd0);
    wr(8'h00, 32'd200);
    wr(8'h1C, 32'd205);
    wd_seen = 0; idle(40);
    check("R8", wd_seen, 32'd0);
    rd("R5", 8'h20);

    // R6 set wins over a same-cycle clear: clear every cycle while the match lands
    wr(8'h20, 32'h3F);
    wr(8'h00, 32'd300);
    wr(8'h10, 32'd304);
    hi_seen = 0;
    @(negedge clk); we = 1; addr = 8'h20; wdata = 32'h4;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #0.5;
      check("R6", rdata, exp_rd(8'h20));
      if (rdata[2]) hi_seen++;
    end
    we = 0;
    check("R6", hi_seen, 32'd1);

    // random traffic
    for (int it = 0; it < 3000; it++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0, 1: wr(8'(8 + 4 * $urandom_range(0, 5)), m_cnt[31:0] + $urandom_range(0, 12));
        2: wr(8'h24, $urandom);
        3: wr(8'h28, $urandom);
        4: wr(8'h2C, $urandom_range(0, 3));
        5: wr(8'h20, $urandom);
        6: wr(8'h30, $urandom);
        7: wr(($urandom_range(0, 7) == 0) ? 8'h04 : 8'h00, $urandom);
        default: rd("R9", 8'(4 * $urandom_range(0, 20)));
      endcase
      if (it % 16 == 0) begin rd("R5", 8'h20); rd("R3", 8'h00); end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule